// File: doc/BRIEF.md
# Synchronous FIFO with programmable flags

A single-clock first-in first-out buffer that stores `W`-bit words (18 by default) in a memory of `DEPTH` words (1024 by default, a power of two). The output behaviour and the default thresholds of the two programmable flags are captured while master reset is held. In standard mode a read request places the next word on the output register one edge later, and the status pins report empty and full. In first-word-fall-through mode the head word appears at the output without a request, and the status pins report output-ready and input-ready.

Besides the two status pins, the block drives a half-full flag and two threshold flags whose limits live in two offset registers: one for the almost-empty flag and one for the almost-full flag. Pulling the offset-access input low sends writes and reads to these registers instead of the FIFO memory. A mark input saves the read position of the head word, and a rewind request puts the read pointer back at that position so the same data can be read again.

Top module: `prog_flag_fifo`

## Requirements
- R1: While `rst_ni` is low the read pointer, write pointer, saved mark and output register are cleared. `dout_o` reads 0 and the FIFO holds no words.
- R2: Configuration is captured at every rising edge while `rst_ni` is low and at the first rising edge after release. `fwft_sel_i`=0 selects standard mode. In that mode `out_stat_o`=1 means empty and `in_stat_o`=1 means `DEPTH` words are stored. `fwft_sel_i`=1 selects fall-through mode.
- R3: In fall-through mode the head word is loaded into `dout_o` with no read request, one edge after it becomes available. `out_stat_o`=1 while `dout_o` holds a valid word. `in_stat_o`=1 while the occupancy is below `DEPTH`. A read with `out_stat_o`=1 moves to the next word. Occupancy counts the word held at the output.
- R4: `ae_o` is 1 when occupancy is greater than or equal to the empty offset n, and 0 when it is below n.
- R5: `af_o` is 1 when the free space (`DEPTH` minus occupancy) is greater than the full offset m, and 0 otherwise.
- R6: `hf_o` is 1 exactly when occupancy exceeds `DEPTH`/2.
- R7: The default offsets are captured with the mode. Let idx = {`ofs_acc_ni`, `fsel_i[1]`, `fsel_i[0]`}. Then n = m = min(2^(idx+3) - 1, `DEPTH` - 1), giving 7, 15, 31, ... 1023 before the clamp.
- R8: When `ofs_acc_ni`=0, a write stores `din_i[CW-1:0]` into n, then into m, alternating, with the first write after reset going to n. In standard mode a read places the zero-extended n, then m, alternating, on `dout_o` one edge later. In fall-through mode such reads are ignored. Offset accesses never move the FIFO pointers.
- R9: A write while full and a read while empty are ignored: no pointer moves and `dout_o` keeps its value.
- R10: A `mark_i` pulse saves the position of the current head word. A `rt_i` pulse returns the read pointer to the saved position and takes priority over a read in the same cycle. In fall-through mode the head word is fetched again one edge later.
- R11: In standard mode a read of a non-empty FIFO presents the oldest unread word on `dout_o` one edge later, in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low master reset; configuration is captured while it is low |
| fwft_sel_i | input | 1 | Mode select, sampled at reset: 0 standard, 1 fall-through |
| fsel_i | input | 2 | Default offset select, sampled at reset |
| ofs_acc_ni | input | 1 | Low: route accesses to the offset registers; sampled at reset as the default select MSB |
| wen_i | input | 1 | Write request |
| din_i | input | W | Write data |
| ren_i | input | 1 | Read request |
| mark_i | input | 1 | Save the head read position |
| rt_i | input | 1 | Rewind the read pointer to the saved position |
| dout_o | output | W | Output data register |
| out_stat_o | output | 1 | Empty (standard) or output-ready (fall-through) |
| in_stat_o | output | 1 | Full (standard) or input-ready (fall-through) |
| ae_o | output | 1 | Almost-empty threshold flag |
| af_o | output | 1 | Almost-full threshold flag |
| hf_o | output | 1 | Half-full flag |

## Verification
The properties assume that the configuration pins are stable from the last reset edge through the capture edge. They also assume that a rewind is only requested after a mark, while the marked data has not yet been overwritten by the write side. The stimulus meets these assumptions as follows. It changes the mode, offset-select and offset-access pins only at falling edges, and it returns `ofs_acc_ni` high only after the capture edge. It places every mark before the rewind that uses it. It keeps the occupancy between mark and rewind within `DEPTH`.

// File: rtl/pff_pkg.sv
package pff_pkg;
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} pff_mode_e;

  typedef struct packed {
    pff_mode_e  mode;
    logic [2:0] idx;
  } pff_cfg_t;

  function automatic int unsigned dflt_ofs(input logic [2:0] idx, input int unsigned depth);
    int unsigned v;
    v = (32'd8 << idx) - 32'd1;
    return (v > depth - 1) ? depth - 1 : v;
  endfunction
endpackage

// File: rtl/pff_store.sv
module pff_store #(
  parameter int unsigned W     = 18,
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pff_ofs.sv
module pff_ofs
  import pff_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_dflt_i,
  input  logic [2:0]    dflt_idx_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] n_o,
  output logic [CW-1:0] m_o,
  output logic [CW-1:0] rdata_o
);
  logic          wsel_q, rsel_q;
  logic [CW-1:0] n_q, m_q, dflt;

  assign dflt = CW'(dflt_ofs(dflt_idx_i, DEPTH));

  // alternation: first access of each direction hits n
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wsel_q <= 1'b0;
      rsel_q <= 1'b0;
    end else begin
      if (wr_i) wsel_q <= ~wsel_q;
      if (rd_i) rsel_q <= ~rsel_q;
    end
  end

  always_ff @(posedge clk_i) begin
    if (load_dflt_i) begin
      n_q <= dflt;
      m_q <= dflt;
    end else if (wr_i) begin
      if (!wsel_q) n_q <= wdata_i;
      else         m_q <= wdata_i;
    end
  end

  assign n_o     = n_q;
  assign m_o     = m_q;
  assign rdata_o = rsel_q ? m_q : n_q;
endmodule

// File: rtl/pff_flags.sv
module pff_flags #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned CW    = $clog2(DEPTH) + 1
) (
  input  logic [CW-1:0] occ_i,
  input  logic [CW-1:0] n_i,
  input  logic [CW-1:0] m_i,
  output logic          ae_o,
  output logic          af_o,
  output logic          hf_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C  = CW'(DEPTH / 2);

  logic [CW-1:0] free;

  assign free = DEPTH_C - occ_i;
  assign ae_o = occ_i >= n_i;
  assign af_o = free > m_i;
  assign hf_o = occ_i > HALF_C;
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
  import pff_pkg::*;
#(
  parameter int unsigned W     = 18,
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fwft_sel_i,
  input  logic [1:0]   fsel_i,
  input  logic         ofs_acc_ni,
  input  logic         wen_i,
  input  logic [W-1:0] din_i,
  input  logic         ren_i,
  input  logic         mark_i,
  input  logic         rt_i,
  output logic [W-1:0] dout_o,
  output logic         out_stat_o,
  output logic         in_stat_o,
  output logic         ae_o,
  output logic         af_o,
  output logic         hf_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic          in_rst_q;
  pff_cfg_t      cfg_q;
  logic          fwft;
  logic [CW-1:0] wptr, rptr, mark_q, cnt_mem, occ;
  logic          ov_q;
  logic [W-1:0]  dout_q, mem_rdata;
  logic [CW-1:0] ofs_n, ofs_m, ofs_rdata;
  logic          acc, full, wr_ok, pop, rd_adv, ofs_rd, ofs_wr;

  // high during reset and for the first edge after release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_rst_q <= 1'b1;
    else         in_rst_q <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (in_rst_q) begin
      cfg_q.mode <= fwft_sel_i ? MODE_FWFT : MODE_STD;
      cfg_q.idx  <= {ofs_acc_ni, fsel_i};
    end
  end

  assign fwft    = (cfg_q.mode == MODE_FWFT);
  assign acc     = ~ofs_acc_ni;
  assign cnt_mem = wptr - rptr;
  assign occ     = cnt_mem + CW'(fwft & ov_q);
  assign full    = (occ == DEPTH_C);
  assign wr_ok   = wen_i & ~acc & ~full;
  assign pop     = ren_i & ~acc & ~rt_i & ov_q;
  assign ofs_wr  = wen_i & acc;
  assign ofs_rd  = ren_i & acc & ~fwft;

  always_comb begin
    if (fwft) rd_adv = ~rt_i & (cnt_mem != '0) & (~ov_q | pop);
    else      rd_adv = ren_i & ~acc & ~rt_i & (cnt_mem != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr   <= '0;
      rptr   <= '0;
      mark_q <= '0;
      ov_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (mark_i) mark_q <= rptr - CW'(fwft & ov_q);
      if (rt_i) begin
        rptr <= mark_q;
        ov_q <= 1'b0;
      end else if (rd_adv) begin
        rptr   <= rptr + 1'b1;
        dout_q <= mem_rdata;
        ov_q   <= fwft;
      end else if (pop) begin
        ov_q <= 1'b0;
      end
      if (ofs_rd) dout_q <= W'(ofs_rdata);
    end
  end

  pff_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .we_i    (wr_ok),
    .waddr_i (wptr[AW-1:0]),
    .wdata_i (din_i),
    .raddr_i (rptr[AW-1:0]),
    .rdata_o (mem_rdata)
  );

  pff_ofs #(.DEPTH(DEPTH), .CW(CW)) u_ofs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_dflt_i (in_rst_q),
    .dflt_idx_i  ({ofs_acc_ni, fsel_i}),
    .wr_i        (ofs_wr),
    .rd_i        (ofs_rd),
    .wdata_i     (din_i[CW-1:0]),
    .n_o         (ofs_n),
    .m_o         (ofs_m),
    .rdata_o     (ofs_rdata)
  );

  pff_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
    .occ_i (occ),
    .n_i   (ofs_n),
    .m_i   (ofs_m),
    .ae_o  (ae_o),
    .af_o  (af_o),
    .hf_o  (hf_o)
  );

  assign dout_o     = dout_q;
  assign out_stat_o = fwft ? ov_q : (cnt_mem == '0);
  assign in_stat_o  = fwft ? ~full : full;
endmodule

// File: rtl/pff_chk.sv
module pff_chk #(
  parameter int unsigned W  = 18,
  parameter int unsigned CW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fwft,
  input logic          ofs_acc_ni,
  input logic          wen_i,
  input logic          ren_i,
  input logic          rt_i,
  input logic          out_stat_o,
  input logic          in_stat_o,
  input logic          hf_o,
  input logic [W-1:0]  dout_o,
  input logic [CW-1:0] wptr,
  input logic [CW-1:0] rptr,
  input logic [CW-1:0] mark_q
);
  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwft && in_stat_o && wen_i) |=> $stable(wptr));

  a_r9_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwft && out_stat_o && ren_i && ofs_acc_ni && !rt_i) |=> ($stable(rptr) && $stable(dout_o)));

  a_r10_rewind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_i |=> (rptr == $past(mark_q)));

  a_r3_head_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwft && out_stat_o && !ren_i && !rt_i) |=> (out_stat_o && $stable(dout_o)));

  a_r6_half_not_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hf_o |-> !(!fwft && out_stat_o));

  a_r2_empty_full_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fwft |-> !(out_stat_o && in_stat_o));
endmodule

bind prog_flag_fifo pff_chk #(.W(W), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fwft       (fwft),
  .ofs_acc_ni (ofs_acc_ni),
  .wen_i      (wen_i),
  .ren_i      (ren_i),
  .rt_i       (rt_i),
  .out_stat_o (out_stat_o),
  .in_stat_o  (in_stat_o),
  .hf_o       (hf_o),
  .dout_o     (dout_o),
  .wptr       (wptr),
  .rptr       (rptr),
  .mark_q     (mark_q)
);

// File: tb/prog_flag_fifo_tb_top.sv
`timescale 1ns/1ps
module prog_flag_fifo_tb_top;
  localparam int W = 18;
  localparam int DEPTH = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         fwft_sel_i = 1'b0;
  logic [1:0]   fsel_i = '0;
  logic         ofs_acc_ni = 1'b0;
  logic         wen_i = 1'b0;
  logic [W-1:0] din_i = '0;
  logic         ren_i = 1'b0;
  logic         mark_i = 1'b0;
  logic         rt_i = 1'b0;
  logic [W-1:0] dout_o;
  logic         out_stat_o, in_stat_o, ae_o, af_o, hf_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_cnt = 0;

  always #4 clk_i = ~clk_i;

  prog_flag_fifo #(.W(W), .DEPTH(DEPTH)) dut_i (.*);

  always @(posedge clk_i) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=done", cyc_cnt);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [W-1:0] d);
    wen_i = 1'b1; din_i = d; cyc(); wen_i = 1'b0;
  endtask

  task automatic rd();
    ren_i = 1'b1; cyc(); ren_i = 1'b0;
  endtask

  task automatic do_reset(input logic fw, input logic [2:0] idx);
    @(negedge clk_i);
    rst_ni = 1'b0; fwft_sel_i = fw; ofs_acc_ni = idx[2]; fsel_i = idx[1:0];
    cyc(); cyc(); cyc();
    rst_ni = 1'b1;
    cyc();
    ofs_acc_ni = 1'b1;
  endtask

  function automatic int dflt(input int idx);
    int v = (8 << idx) - 1;
    return (v > DEPTH - 1) ? DEPTH - 1 : v;
  endfunction

  task automatic chk_flags(input bit fw, input int occ, input int n, input int m, input string tag);
    chk({tag, " R2/R3 out_stat"}, 32'(out_stat_o), fw ? 32'(occ != 0) : 32'(occ == 0));
    chk({tag, " R2/R3 in_stat"},  32'(in_stat_o),  fw ? 32'(occ != DEPTH) : 32'(occ == DEPTH));
    chk({tag, " R4 ae"}, 32'(ae_o), 32'(occ >= n));
    chk({tag, " R5 af"}, 32'(af_o), 32'((DEPTH - occ) > m));
    chk({tag, " R6 hf"}, 32'(hf_o), 32'(occ > DEPTH / 2));
  endtask

  initial begin
    int ns[4];
    int ms[4];
    logic [W-1:0] seq[16];
    ns = '{3, 0, 8, 15};
    ms = '{5, 0, 12, 15};

    // R1 reset state, R7 defaults
    do_reset(1'b0, 3'd0);
    chk("R1 dout", 32'(dout_o), 0);
    chk_flags(1'b0, 0, 7, 7, "R1");
    ofs_acc_ni = 1'b0; rd(); chk("R7 n idx0", 32'(dout_o), 7);
    rd(); chk("R7 m idx0", 32'(dout_o), 7);
    ofs_acc_ni = 1'b1;
    foreach (ns[j]) begin
      int idx = (j == 0) ? 1 : (j == 1) ? 2 : (j == 2) ? 5 : 6;
      do_reset(1'b0, 3'(idx));
      ofs_acc_ni = 1'b0; rd(); chk("R7 n dflt", 32'(dout_o), 32'(dflt(idx)));
      rd(); chk("R7 m dflt", 32'(dout_o), 32'(dflt(idx)));
      ofs_acc_ni = 1'b1;
    end

    // R8 programming, R4-R6 threshold sweep, R11 ordering, R9 ignore
    for (int k = 0; k < 4; k++) begin
      do_reset(1'b0, 3'd0);
      ofs_acc_ni = 1'b0;
      wr(W'(ns[k])); wr(W'(ms[k]));
      rd(); chk("R8 read n", 32'(dout_o), 32'(ns[k]));
      rd(); chk("R8 read m", 32'(dout_o), 32'(ms[k]));
      ofs_acc_ni = 1'b1;
      chk("R8 pointers untouched", 32'(out_stat_o), 1);
      for (int i = 0; i < DEPTH; i++) begin
        wr(W'(k * 64 + i));
        chk_flags(1'b0, i + 1, ns[k], ms[k], "fill");
      end
      wr(W'(18'h3ffff));
      chk_flags(1'b0, DEPTH, ns[k], ms[k], "R9 write full");
      for (int i = 0; i < DEPTH; i++) begin
        rd();
        chk("R11 order", 32'(dout_o), 32'(k * 64 + i));
        chk_flags(1'b0, DEPTH - 1 - i, ns[k], ms[k], "drain");
      end
      rd();
      chk("R9 read empty dout", 32'(dout_o), 32'(k * 64 + DEPTH - 1));
      chk_flags(1'b0, 0, ns[k], ms[k], "R9 read empty");
    end

    // R10 standard mode mark and rewind
    do_reset(1'b0, 3'd0);
    for (int i = 0; i < 6; i++) wr(W'(18'h100 + i));
    rd(); rd();
    mark_i = 1'b1; cyc(); mark_i = 1'b0;
    rd(); chk("R10 pre", 32'(dout_o), 32'h102);
    rd();
    rt_i = 1'b1; cyc(); rt_i = 1'b0;
    chk_flags(1'b0, 4, 7, 7, "R10 rewound");
    rd(); chk("R10 reread", 32'(dout_o), 32'h102);

    // R3 fall-through mode
    do_reset(1'b1, 3'd0);
    chk("R2 fwft not ready", 32'(out_stat_o), 0);
    chk("R2 fwft input ready", 32'(in_stat_o), 1);
    wr(W'(18'h2a)); cyc();
    chk("R3 fall through", 32'(dout_o), 32'h2a);
    chk("R3 ready", 32'(out_stat_o), 1);
    wr(W'(18'h2b)); wr(W'(18'h2c)); cyc();
    chk("R3 head held", 32'(dout_o), 32'h2a);
    chk_flags(1'b1, 3, 7, 7, "R3 occ3");
    rd(); chk("R3 advance", 32'(dout_o), 32'h2b);
    ofs_acc_ni = 1'b0; rd(); ofs_acc_ni = 1'b1;
    chk("R8 fwft offset read ignored", 32'(dout_o), 32'h2b);
    chk_flags(1'b1, 2, 7, 7, "R8 fwft");
    seq[0] = W'(18'h2b); seq[1] = W'(18'h2c);
    for (int i = 0; i < 14; i++) begin
      seq[i + 2] = W'(18'h30 + i);
      wr(seq[i + 2]);
      chk_flags(1'b1, i + 3, 7, 7, "R3 fill");
    end
    wr(W'(18'h3f));
    chk_flags(1'b1, DEPTH, 7, 7, "R9 fwft full");
    mark_i = 1'b1; cyc(); mark_i = 1'b0;
    rd(); chk("R10 fwft pre", 32'(dout_o), 32'h2c);
    rd();
    rt_i = 1'b1; cyc(); rt_i = 1'b0;
    cyc();
    chk("R10 fwft rewind", 32'(dout_o), 32'h2b);
    chk_flags(1'b1, DEPTH, 7, 7, "R10 fwft");
    for (int k = 0; k < DEPTH; k++) begin
      rd();
      if (k < DEPTH - 1) chk("R3 drain", 32'(dout_o), 32'(seq[k + 1]));
      chk_flags(1'b1, DEPTH - 1 - k, 7, 7, "R3 drain");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule